// File: doc/BRIEF.md
# Write-Back Cache with Flush Control

This block is a small direct-mapped data cache that sits between a word-wide load/store request port and a memory port that moves one whole line per transaction. Hits are served from the line array, and the response appears on the cycle after the request is accepted. A miss stalls the request port. If the line being displaced holds modified data, the block writes that line back first. It then reads the complete new line from memory and replays the stalled request against it. Writes follow a write-allocate, write-back policy: a store to a resident line only updates the array and marks the line modified.

The block also accepts two whole-cache maintenance commands. Flush walks every line index from the lowest to the highest and writes back each modified line. Only after that walk does it drop all lines. Discard drops all lines at once and never touches memory, so any modified data is lost. Both commands report completion with a single-cycle done pulse. The line size is a parameter, and the supported values are 32 or 64 bytes. Lines are aligned to their own size.

Top module: `flush_cache`

## Requirements
- R1: A line covers an aligned region of LINE_BYTES bytes. With 32-byte lines, byte addresses 0x004 and 0x01C fall in one line, so the second access after a fill of the first is a hit and causes no memory transaction.
- R2: A read hit asserts respValid with the addressed word on the cycle right after the request is accepted, and no memory request is made.
- R3: A write hit replaces only the bytes whose reqBe bit is set (bit n selects bits 8n+7..8n of the word), marks the line modified and issues no memory transaction.
- R4: A miss issues exactly one memory read whose memAddr is the line-aligned byte address (offset bits zero), writes the whole returned line into the array and then completes the original request.
- R5: When the displaced line is valid and modified, its full line is written to memory before the fill read is issued. A clean or invalid victim produces no write.
- R6: Flush (cmdValid with cmdFlush=1) writes back every modified line one transaction at a time in ascending index order. It then invalidates all lines and raises cmdDone for exactly one cycle.
- R7: Discard (cmdValid with cmdFlush=0) invalidates all lines without any memory write. Modified data is lost, and a later read returns the memory contents.
- R8: reqReady is low while a miss, a writeback or a maintenance command is in progress. A command presented in the idle state takes priority over a request.
- R9: After reset all lines are invalid, reqReady is high, and respValid, memValid and cmdDone are low.
- R10: Once memValid is raised, memValid, memWe and memAddr hold steady until memReady is seen high at a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Load/store request present |
| reqReady | output | 1 | Request accepted at this edge when high |
| reqWe | input | 1 | 1 = store, 0 = load |
| reqWordAddr | input | ADDR_W-2 | Word address of the access |
| reqWData | input | 32 | Store data |
| reqBe | input | 4 | Store byte enables |
| respValid | output | 1 | One-cycle completion of a load or store |
| respRData | output | 32 | Load data, valid with respValid on loads |
| cmdValid | input | 1 | Maintenance command present |
| cmdFlush | input | 1 | 1 = write back then invalidate, 0 = discard |
| cmdDone | output | 1 | One-cycle pulse when a command completes |
| memValid | output | 1 | Memory transaction request |
| memReady | input | 1 | Memory accepts the request at this edge |
| memWe | output | 1 | 1 = line write, 0 = line read |
| memAddr | output | ADDR_W | Line-aligned byte address |
| memWData | output | LINE_BYTES*8 | Line data for writes |
| memRValid | input | 1 | Read line returned |
| memRData | input | LINE_BYTES*8 | Returned line data |

## Verification
The bench goes after a store to a partly enabled word. A merge that ignored reqBe would corrupt the neighbouring bytes of the refetched word. It forces a conflict eviction of a modified line and checks both the written-back memory image and that the write landed before the fill read; a design that filled first or skipped the dirty check would lose the store. Flush is run with two modified lines at the low and high ends of the index range, which exposes a walk that stops early, repeats an index or writes clean lines. Discard is run with a modified line present, so a design that wrote it back, or kept the line valid, would return the stored value instead of the old memory word.

// File: rtl/flush_cache_pkg.sv
package flush_cache_pkg;

  typedef enum logic [1:0] {
    ADDR_VICTIM = 2'd0,
    ADDR_FILL   = 2'd1,
    ADDR_WALK   = 2'd2
  } memAddrSel_e;

  typedef struct packed {
    logic        useLatched;
    logic        latchReq;
    logic        doAccess;
    logic        fillWrite;
    logic        markClean;
    logic        clearAll;
    memAddrSel_e addrSel;
  } ctrlStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MISS_WB,
    ST_MISS_FILL,
    ST_MISS_WAIT,
    ST_REPLAY,
    ST_FL_SCAN,
    ST_FL_WB,
    ST_CLEAR
  } ctrlState_e;

endpackage

// File: rtl/flush_cache_ctrl.sv
module flush_cache_ctrl
  import flush_cache_pkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic              cmdValid,
  input  logic              cmdFlush,
  input  logic              memReady,
  input  logic              memRValid,
  input  logic              hit,
  input  logic              victimDirty,
  input  logic              walkDirty,
  output ctrlStrobe_t       strobe,
  output logic [IDX_W-1:0]  walkIdx,
  output logic              reqReady,
  output logic              memValid,
  output logic              memWe,
  output logic              cmdDone
);

  ctrlState_e state, nextState;
  logic [IDX_W-1:0] walkNext;
  logic walkLast;

  assign walkLast = (walkIdx == IDX_W'(NUM_LINES - 1));
  assign reqReady = (state == ST_IDLE) && !cmdValid;
  assign cmdDone  = (state == ST_CLEAR);

  always_comb begin
    strobe         = '0;
    strobe.addrSel = ADDR_FILL;
    nextState      = state;
    walkNext       = walkIdx;
    memValid       = 1'b0;
    memWe          = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (cmdValid) begin
          if (cmdFlush) begin
            nextState = ST_FL_SCAN;
            walkNext  = '0;
          end else begin
            nextState = ST_CLEAR;
          end
        end else if (reqValid) begin
          if (hit) begin
            strobe.doAccess = 1'b1;
          end else begin
            strobe.latchReq = 1'b1;
            nextState = victimDirty ? ST_MISS_WB : ST_MISS_FILL;
          end
        end
      end
      ST_MISS_WB: begin
        memValid       = 1'b1;
        memWe          = 1'b1;
        strobe.addrSel = ADDR_VICTIM;
        if (memReady) begin
          strobe.markClean = 1'b1;
          nextState        = ST_MISS_FILL;
        end
      end
      ST_MISS_FILL: begin
        memValid = 1'b1;
        if (memReady) nextState = ST_MISS_WAIT;
      end
      ST_MISS_WAIT: begin
        if (memRValid) begin
          strobe.fillWrite = 1'b1;
          nextState        = ST_REPLAY;
        end
      end
      ST_REPLAY: begin
        strobe.useLatched = 1'b1;
        strobe.doAccess   = 1'b1;
        nextState         = ST_IDLE;
      end
      ST_FL_SCAN: begin
        strobe.addrSel = ADDR_WALK;
        if (walkDirty)     nextState = ST_FL_WB;
        else if (walkLast) nextState = ST_CLEAR;
        else               walkNext  = walkIdx + 1'b1;
      end
      ST_FL_WB: begin
        memValid       = 1'b1;
        memWe          = 1'b1;
        strobe.addrSel = ADDR_WALK;
        if (memReady) begin
          strobe.markClean = 1'b1;
          if (walkLast) begin
            nextState = ST_CLEAR;
          end else begin
            walkNext  = walkIdx + 1'b1;
            nextState = ST_FL_SCAN;
          end
        end
      end
      ST_CLEAR: begin
        strobe.clearAll = 1'b1;
        nextState       = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      walkIdx <= '0;
    end else begin
      state   <= nextState;
      walkIdx <= walkNext;
    end
  end

endmodule

// File: rtl/flush_cache_dp.sv
module flush_cache_dp
  import flush_cache_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int LINE_BYTES = 32,
  parameter int NUM_LINES  = 8,
  parameter int WORD_BYTES = 4,
  localparam int LINE_BITS  = LINE_BYTES * 8,
  localparam int WORD_BITS  = WORD_BYTES * 8,
  localparam int OFF_W      = $clog2(LINE_BYTES),
  localparam int BOFF_W     = $clog2(WORD_BYTES),
  localparam int IDX_W      = $clog2(NUM_LINES),
  localparam int WSEL_W     = OFF_W - BOFF_W,
  localparam int WA_W       = ADDR_W - BOFF_W,
  localparam int TAG_W      = ADDR_W - OFF_W - IDX_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  ctrlStrobe_t           strobe,
  input  logic [IDX_W-1:0]      walkIdx,
  input  logic                  reqWe,
  input  logic [WA_W-1:0]       reqWordAddr,
  input  logic [WORD_BITS-1:0]  reqWData,
  input  logic [WORD_BYTES-1:0] reqBe,
  input  logic [LINE_BITS-1:0]  memRData,
  output logic                  hit,
  output logic                  victimDirty,
  output logic                  walkDirty,
  output logic                  respValid,
  output logic [WORD_BITS-1:0]  respRData,
  output logic [ADDR_W-1:0]     memAddr,
  output logic [LINE_BITS-1:0]  memWData
);

  logic [LINE_BITS-1:0] dataArr [NUM_LINES];
  logic [TAG_W-1:0]     tagArr  [NUM_LINES];
  logic [NUM_LINES-1:0] validArr, dirtyArr;

  logic                  latWe;
  logic [WA_W-1:0]       latWordAddr;
  logic [WORD_BITS-1:0]  latWData;
  logic [WORD_BYTES-1:0] latBe;

  logic                  curWe;
  logic [WA_W-1:0]       curWordAddr;
  logic [WORD_BITS-1:0]  curWData;
  logic [WORD_BYTES-1:0] curBe;
  logic [IDX_W-1:0]      curIdx, latIdx, cleanIdx;
  logic [TAG_W-1:0]      curTag, latTag;
  logic [WSEL_W-1:0]     curWsel;
  logic [LINE_BITS-1:0]  mergedLine;

  assign curWe       = strobe.useLatched ? latWe       : reqWe;
  assign curWordAddr = strobe.useLatched ? latWordAddr : reqWordAddr;
  assign curWData    = strobe.useLatched ? latWData    : reqWData;
  assign curBe       = strobe.useLatched ? latBe       : reqBe;

  assign curWsel = curWordAddr[WSEL_W-1:0];
  assign curIdx  = curWordAddr[WSEL_W +: IDX_W];
  assign curTag  = curWordAddr[WA_W-1 -: TAG_W];
  assign latIdx  = latWordAddr[WSEL_W +: IDX_W];
  assign latTag  = latWordAddr[WA_W-1 -: TAG_W];

  assign hit         = validArr[curIdx] && (tagArr[curIdx] == curTag);
  assign victimDirty = validArr[curIdx] && dirtyArr[curIdx];
  assign walkDirty   = validArr[walkIdx] && dirtyArr[walkIdx];
  assign cleanIdx    = (strobe.addrSel == ADDR_WALK) ? walkIdx : latIdx;

  always_comb begin
    mergedLine = dataArr[curIdx];
    for (int b = 0; b < WORD_BYTES; b++) begin
      if (curBe[b])
        mergedLine[(int'(curWsel) * WORD_BYTES + b) * 8 +: 8] = curWData[b * 8 +: 8];
    end
  end

  always_comb begin
    memAddr  = {latTag, latIdx, {OFF_W{1'b0}}};
    memWData = '0;
    unique case (strobe.addrSel)
      ADDR_VICTIM: begin
        memAddr  = {tagArr[latIdx], latIdx, {OFF_W{1'b0}}};
        memWData = dataArr[latIdx];
      end
      ADDR_WALK: begin
        memAddr  = {tagArr[walkIdx], walkIdx, {OFF_W{1'b0}}};
        memWData = dataArr[walkIdx];
      end
      default: ;
    endcase
  end

  // Line payload and tags carry no reset; the valid bits gate their use.
  always_ff @(posedge clk) begin
    if (strobe.fillWrite) begin
      dataArr[latIdx] <= memRData;
      tagArr[latIdx]  <= latTag;
    end else if (strobe.doAccess && curWe) begin
      dataArr[curIdx] <= mergedLine;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      validArr    <= '0;
      dirtyArr    <= '0;
      respValid   <= 1'b0;
      respRData   <= '0;
      latWe       <= 1'b0;
      latWordAddr <= '0;
      latWData    <= '0;
      latBe       <= '0;
    end else begin
      respValid <= strobe.doAccess;
      if (strobe.doAccess && !curWe)
        respRData <= dataArr[curIdx][int'(curWsel) * WORD_BITS +: WORD_BITS];
      if (strobe.latchReq) begin
        latWe       <= reqWe;
        latWordAddr <= reqWordAddr;
        latWData    <= reqWData;
        latBe       <= reqBe;
      end
      if (strobe.clearAll) begin
        validArr <= '0;
        dirtyArr <= '0;
      end else begin
        if (strobe.fillWrite) begin
          validArr[latIdx] <= 1'b1;
          dirtyArr[latIdx] <= 1'b0;
        end
        if (strobe.markClean) dirtyArr[cleanIdx] <= 1'b0;
        if (strobe.doAccess && curWe) dirtyArr[curIdx] <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/flush_cache.sv
module flush_cache
  import flush_cache_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int LINE_BYTES = 32,
  parameter int NUM_LINES  = 8,
  localparam int WORD_BYTES = 4,
  localparam int WORD_BITS  = WORD_BYTES * 8,
  localparam int LINE_BITS  = LINE_BYTES * 8,
  localparam int WA_W       = ADDR_W - $clog2(WORD_BYTES),
  localparam int IDX_W      = $clog2(NUM_LINES)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reqValid,
  output logic                  reqReady,
  input  logic                  reqWe,
  input  logic [WA_W-1:0]       reqWordAddr,
  input  logic [WORD_BITS-1:0]  reqWData,
  input  logic [WORD_BYTES-1:0] reqBe,
  output logic                  respValid,
  output logic [WORD_BITS-1:0]  respRData,
  input  logic                  cmdValid,
  input  logic                  cmdFlush,
  output logic                  cmdDone,
  output logic                  memValid,
  input  logic                  memReady,
  output logic                  memWe,
  output logic [ADDR_W-1:0]     memAddr,
  output logic [LINE_BITS-1:0]  memWData,
  input  logic                  memRValid,
  input  logic [LINE_BITS-1:0]  memRData
);

  if (!(LINE_BYTES == 32 || LINE_BYTES == 64)) begin : g_bad_line
    $error("LINE_BYTES must be 32 or 64");
  end

  ctrlStrobe_t      strobe;
  logic [IDX_W-1:0] walkIdx;
  logic             lineHit, victimDirty, walkDirty;

  flush_cache_ctrl #(.NUM_LINES(NUM_LINES)) i_ctrl (
    .clk(clk), .rst(rst),
    .reqValid(reqValid), .cmdValid(cmdValid), .cmdFlush(cmdFlush),
    .memReady(memReady), .memRValid(memRValid),
    .hit(lineHit), .victimDirty(victimDirty), .walkDirty(walkDirty),
    .strobe(strobe), .walkIdx(walkIdx), .reqReady(reqReady),
    .memValid(memValid), .memWe(memWe), .cmdDone(cmdDone)
  );

  flush_cache_dp #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES),
    .NUM_LINES(NUM_LINES), .WORD_BYTES(WORD_BYTES)
  ) i_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .walkIdx(walkIdx),
    .reqWe(reqWe), .reqWordAddr(reqWordAddr), .reqWData(reqWData), .reqBe(reqBe),
    .memRData(memRData),
    .hit(lineHit), .victimDirty(victimDirty), .walkDirty(walkDirty),
    .respValid(respValid), .respRData(respRData),
    .memAddr(memAddr), .memWData(memWData)
  );

endmodule

// File: rtl/flush_cache_chk.sv
module flush_cache_chk #(
  parameter int ADDR_W     = 12,
  parameter int LINE_BYTES = 32,
  localparam int OFF_W = $clog2(LINE_BYTES)
) (
  input logic              clk,
  input logic              rst,
  input logic              reqValid,
  input logic              reqReady,
  input logic              lineHit,
  input logic              respValid,
  input logic              cmdDone,
  input logic              memValid,
  input logic              memReady,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr
);

  a_r2_hit_no_memory: assert property (@(posedge clk) disable iff (rst)
    reqValid && reqReady && lineHit |=> respValid && !memValid);

  a_r4_line_aligned: assert property (@(posedge clk) disable iff (rst)
    memValid |-> memAddr[OFF_W-1:0] == '0);

  a_r6_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
    cmdDone |=> !cmdDone);

  a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    (memValid || cmdDone) |-> !reqReady);

  a_r10_request_held: assert property (@(posedge clk) disable iff (rst)
    memValid && !memReady |=> memValid && $stable(memWe) && $stable(memAddr));

endmodule

bind flush_cache flush_cache_chk #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) i_chk (
  .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
  .lineHit(lineHit), .respValid(respValid), .cmdDone(cmdDone),
  .memValid(memValid), .memReady(memReady), .memWe(memWe), .memAddr(memAddr)
);

// File: tb/test_flush_cache.sv
`timescale 1ns/1ps
module test_flush_cache;
  localparam int ADDR_W = 12, LINE_BYTES = 32, NUM_LINES = 8;
  localparam int LINE_BITS = LINE_BYTES * 8;
  localparam int MEM_LINES = (1 << ADDR_W) / LINE_BYTES;

  logic clk = 1'b0, rst = 1'b1;
  logic reqValid = 1'b0, reqWe = 1'b0, cmdValid = 1'b0, cmdFlush = 1'b0;
  logic [ADDR_W-3:0] reqWordAddr = '0;
  logic [31:0] reqWData = '0;
  logic [3:0] reqBe = '0;
  logic reqReady, respValid, cmdDone, memValid, memWe, memReady, memRValid;
  logic [31:0] respRData;
  logic [ADDR_W-1:0] memAddr;
  logic [LINE_BITS-1:0] memWData, memRData;

  always #10 clk = ~clk;

  flush_cache #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .NUM_LINES(NUM_LINES)) i_flush_cache (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady), .reqWe(reqWe),
    .reqWordAddr(reqWordAddr), .reqWData(reqWData), .reqBe(reqBe),
    .respValid(respValid), .respRData(respRData),
    .cmdValid(cmdValid), .cmdFlush(cmdFlush), .cmdDone(cmdDone),
    .memValid(memValid), .memReady(memReady), .memWe(memWe), .memAddr(memAddr),
    .memWData(memWData), .memRValid(memRValid), .memRData(memRData)
  );

  // Memory responder with a stall every fourth cycle and a two-cycle read delay.
  logic [LINE_BITS-1:0] mem [MEM_LINES];
  logic [ADDR_W-1:0] wrLog [16];
  int wrCount, rdCount, rdSeenWr, holdErrs, cyc, rdDelay;
  logic [ADDR_W-OFF-1:0] rdLine;
  localparam int OFF = $clog2(LINE_BYTES);
  logic pendValid;
  logic [ADDR_W-1:0] pendAddr;

  always @(posedge clk) begin
    if (rst) begin
      for (int l = 0; l < MEM_LINES; l++)
        for (int w = 0; w < LINE_BYTES / 4; w++)
          mem[l][w*32 +: 32] <= 32'h5A000000 + 32'(l * LINE_BYTES + w * 4);
      wrCount <= 0; rdCount <= 0; rdSeenWr <= 0; holdErrs <= 0; cyc <= 0;
      rdDelay <= 0; rdLine <= '0; memReady <= 1'b0; memRValid <= 1'b0;
      memRData <= '0; pendValid <= 1'b0; pendAddr <= '0;
    end else begin
      cyc <= cyc + 1;
      memReady <= (cyc % 4) != 3;
      memRValid <= 1'b0;
      if (rdDelay == 1) begin
        memRValid <= 1'b1;
        memRData <= mem[rdLine];
      end
      if (rdDelay != 0) rdDelay <= rdDelay - 1;
      if (pendValid && !(memValid && memAddr == pendAddr)) holdErrs <= holdErrs + 1;
      pendValid <= memValid && !memReady;
      pendAddr <= memAddr;
      if (memValid && memReady) begin
        if (memWe) begin
          mem[memAddr[ADDR_W-1:OFF]] <= memWData;
          wrLog[wrCount[3:0]] <= memAddr;
          wrCount <= wrCount + 1;
        end else begin
          rdLine <= memAddr[ADDR_W-1:OFF];
          rdDelay <= 2;
          rdCount <= rdCount + 1;
          rdSeenWr <= wrCount;
        end
      end
    end
  end

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doReq(input logic we, input logic [11:0] a, input logic [31:0] d,
                       input logic [3:0] be, output logic [31:0] rd, output logic busy, output int lat);
    @(negedge clk);
    reqValid = 1'b1; reqWe = we; reqWordAddr = a[11:2]; reqWData = d; reqBe = be;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    busy = !reqReady;
    lat = 0;
    while (!respValid && lat < 1000) begin @(negedge clk); lat++; end
    rd = respRData;
  endtask

  task automatic doCmd(input logic flush, output logic busy, output int lat, output logic singlePulse);
    @(negedge clk);
    cmdValid = 1'b1; cmdFlush = flush;
    @(negedge clk);
    cmdValid = 1'b0;
    busy = !reqReady;
    lat = 0;
    while (!cmdDone && lat < 1000) begin @(negedge clk); lat++; end
    @(negedge clk);
    singlePulse = !cmdDone;
  endtask

  typedef struct packed {
    logic        we;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [3:0]  be;
    logic [31:0] exp;
    logic [1:0]  fills;
    logic [1:0]  wbs;
  } vec_t;

  localparam vec_t VECS [11] = '{
    '{1'b0, 12'h004, 32'h0,        4'h0, 32'h5A000004, 2'd1, 2'd0},
    '{1'b0, 12'h01C, 32'h0,        4'h0, 32'h5A00001C, 2'd0, 2'd0},
    '{1'b1, 12'h008, 32'h11223344, 4'hF, 32'h0,        2'd0, 2'd0},
    '{1'b0, 12'h008, 32'h0,        4'h0, 32'h11223344, 2'd0, 2'd0},
    '{1'b1, 12'h00C, 32'hAABBCCDD, 4'h3, 32'h0,        2'd0, 2'd0},
    '{1'b0, 12'h00C, 32'h0,        4'h0, 32'h5A00CCDD, 2'd0, 2'd0},
    '{1'b0, 12'h108, 32'h0,        4'h0, 32'h5A000108, 2'd1, 2'd1},
    '{1'b0, 12'h008, 32'h0,        4'h0, 32'h11223344, 2'd1, 2'd0},
    '{1'b1, 12'h020, 32'hDEADBEEF, 4'hF, 32'h0,        2'd1, 2'd0},
    '{1'b0, 12'h0E4, 32'h0,        4'h0, 32'h5A0000E4, 2'd1, 2'd0},
    '{1'b0, 12'h020, 32'h0,        4'h0, 32'hDEADBEEF, 2'd0, 2'd0}
  };

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] rd;
    logic busy, pulse;
    int lat, rd0, wr0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check(reqReady == 1'b1, "R9 reqReady", 32'(reqReady), 32'h1);
    check(respValid == 1'b0 && cmdDone == 1'b0, "R9 resp/done", {respValid, cmdDone}, 32'h0);
    check(memValid == 1'b0, "R9 memValid", 32'(memValid), 32'h0);

    for (int i = 0; i < 11; i++) begin
      rd0 = rdCount; wr0 = wrCount;
      doReq(VECS[i].we, VECS[i].addr, VECS[i].wdata, VECS[i].be, rd, busy, lat);
      check(lat < 1000, "R2 response seen", 32'(lat), 32'h0);
      if (!VECS[i].we) check(rd == VECS[i].exp, "R3/R4 read data", rd, VECS[i].exp);
      check(rdCount - rd0 == int'(VECS[i].fills), "R1/R4 fill count", 32'(rdCount - rd0), 32'(VECS[i].fills));
      check(wrCount - wr0 == int'(VECS[i].wbs), "R5 writeback count", 32'(wrCount - wr0), 32'(VECS[i].wbs));
      if (VECS[i].fills == 0) check(lat == 0, "R2 hit latency", 32'(lat), 32'h0);
      else check(busy, "R8 ready low on miss", 32'(busy), 32'h1);
      if (i == 6) begin
        check(rdSeenWr == wr0 + 1, "R5 writeback before fill", 32'(rdSeenWr), 32'(wr0 + 1));
        check(mem[0][2*32 +: 32] == 32'h11223344, "R5 written word", mem[0][2*32 +: 32], 32'h11223344);
        check(mem[0][3*32 +: 32] == 32'h5A00CCDD, "R3 byte merge", mem[0][3*32 +: 32], 32'h5A00CCDD);
      end
    end

    // R6 flush with dirty lines at index 1 and index 7
    doReq(1'b1, 12'h0E8, 32'h01020304, 4'hF, rd, busy, lat);
    wr0 = wrCount;
    doCmd(1'b1, busy, lat, pulse);
    check(busy, "R8 ready low during flush", 32'(busy), 32'h1);
    check(lat < 1000 && pulse, "R6 done single pulse", 32'(pulse), 32'h1);
    check(wrCount - wr0 == 2, "R6 writeback count", 32'(wrCount - wr0), 32'h2);
    check(wrLog[wr0[3:0]] == 12'h020, "R6 first index", 32'(wrLog[wr0[3:0]]), 32'h020);
    check(wrLog[4'(wr0 + 1)] == 12'h0E0, "R6 second index", 32'(wrLog[4'(wr0 + 1)]), 32'h0E0);
    check(mem[1][31:0] == 32'hDEADBEEF, "R6 data written", mem[1][31:0], 32'hDEADBEEF);
    check(mem[7][2*32 +: 32] == 32'h01020304, "R6 data written", mem[7][2*32 +: 32], 32'h01020304);
    rd0 = rdCount;
    doReq(1'b0, 12'h020, 32'h0, 4'h0, rd, busy, lat);
    check(rdCount - rd0 == 1, "R6 invalidated after flush", 32'(rdCount - rd0), 32'h1);
    check(rd == 32'hDEADBEEF, "R6 refetch data", rd, 32'hDEADBEEF);

    // R7 discard with a modified line present
    doReq(1'b1, 12'h040, 32'hCAFEF00D, 4'hF, rd, busy, lat);
    wr0 = wrCount;
    doCmd(1'b0, busy, lat, pulse);
    check(lat == 0 && pulse, "R7 done single pulse", 32'(lat), 32'h0);
    check(wrCount == wr0, "R7 no writeback", 32'(wrCount - wr0), 32'h0);
    rd0 = rdCount;
    doReq(1'b0, 12'h040, 32'h0, 4'h0, rd, busy, lat);
    check(rdCount - rd0 == 1, "R7 line invalid", 32'(rdCount - rd0), 32'h1);
    check(rd == 32'h5A000040, "R7 modified data lost", rd, 32'h5A000040);

    check(holdErrs == 0, "R10 request held under stall", 32'(holdErrs), 32'h0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule